// File: doc/BRIEF.md
# Real-Time-Clock Bus Transaction Monitor

This block is a passive observer that sits behind an already working I2C event decoder. Each cycle it may be handed one bus event: a start condition, a repeated start, a stop, an address phase in either direction, or a data byte in either direction. It follows only the transfers aimed at the clock device's fixed 7-bit address. It keeps its own copy of the slave's internal register pointer, and reports every register byte that crosses the bus together with its index and direction.

Transfers to any other address produce a one-cycle warning that carries the offending address. When one transfer touches all seven time-keeping registers, the monitor also raises a strobe. The strobe carries the seconds, minutes, hours, day, date, month and year fields, each converted from BCD to plain binary.

Top module: `rtc_bus_monitor`

## Requirements
- R1: After reset the monitor is idle. In the idle state it reports nothing for any event except a start (kind 0), and a start moves it on to wait for an address phase.
- R2: An address event (write kind 3, read kind 4) is accepted only when `ev_byte_i[6:0]` equals 0x68. Any other value pulses `warn_valid_o` with `warn_addr_o` set to that value, and the monitor returns to idle.
- R3: After an accepted address-write, the first data-write (kind 5) loads the pointer with `ev_byte_i[5:0]`. That byte is not reported as an access.
- R4: Each further data-write in the same transfer is reported with `acc_write_o`=1, with `acc_reg_o` set to the current pointer and `acc_data_o` set to the byte.
- R5: A repeated start (kind 1) after the pointer load makes the monitor wait for an address-read. If that address is 0x68, each following data-read (kind 6) is reported with `acc_write_o`=0. A foreign address raises the warning of R2 and returns the monitor to idle.
- R6: The pointer advances by one after every reported byte, and 0x3F advances to 0x00.
- R7: `acc_is_ram_o` is 0 for indices 0 to 7 and 1 for indices 8 to 0x3F.
- R8: A stop (kind 2) in any state returns the monitor to idle. A start outside idle returns it to idle, and so does a repeated start anywhere except after the pointer load. None of these changes the pointer, so an address-read straight after a start reads from the kept pointer.
- R9: Time fields are taken from indices 0 to 6 in the order seconds, minutes, hours, day, date, month, year. Before conversion the byte is masked to bits [6:0], [6:0], [5:0], [2:0], [5:0], [4:0] and [7:0] respectively. Conversion is low nibble plus ten times the high nibble.
- R10: `dt_valid_o` pulses for one cycle, together with the access that completes indices 0 to 6 within one transfer. `dt_write_o` gives that transfer's direction. Capture restarts at each accepted address.
- R11: `acc_sqw32k_o` is 1 exactly with an access to index 7 whose data bits [1:0] are 2'b11, which is the 32768 Hz rate select.
- R12: Every output answers the event sampled on the previous rising clock edge. All output pulses last one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ev_valid_i | input | 1 | Bus event present this cycle |
| ev_kind_i | input | 3 | Event kind: 0 start, 1 repeated start, 2 stop, 3 address-write, 4 address-read, 5 data-write, 6 data-read |
| ev_byte_i | input | 8 | Address (bits 6:0) or data byte |
| acc_valid_o | output | 1 | Register access reported |
| acc_write_o | output | 1 | 1 write, 0 read |
| acc_reg_o | output | 6 | Register index |
| acc_data_o | output | 8 | Data byte |
| acc_is_ram_o | output | 1 | Index lies in general-purpose RAM |
| acc_sqw32k_o | output | 1 | Control access selecting the 32768 Hz rate |
| warn_valid_o | output | 1 | Foreign address seen |
| warn_addr_o | output | 7 | The foreign address |
| dt_valid_o | output | 1 | Full date/time captured |
| dt_write_o | output | 1 | Direction of the capturing transfer |
| dt_sec_o | output | 7 | Seconds, binary |
| dt_min_o | output | 7 | Minutes, binary |
| dt_hour_o | output | 6 | Hours, binary |
| dt_day_o | output | 3 | Day of week, binary |
| dt_date_o | output | 6 | Day of month, binary |
| dt_month_o | output | 5 | Month, binary |
| dt_year_o | output | 8 | Year, binary |

## Verification
Some properties are checked on every cycle. A stop always lands the monitor in idle. The pointer steps by exactly one with each reported byte, and a rejected address always leaves the monitor idle. An access and a warning never coincide, and the date/time strobe is always raised by an access and leaves the capture mask empty. Only the bench's scenarios can show the rest: the pointer value loaded by a write, wrap-around in a long read burst, the BCD field values, current-address reads from a kept pointer, and the events that are ignored after a misplaced start.

// File: rtl/rtc_mon_pkg.sv
package rtc_mon_pkg;

  typedef enum logic [2:0] {
    EV_START   = 3'd0,
    EV_RSTART  = 3'd1,
    EV_STOP    = 3'd2,
    EV_ADDR_WR = 3'd3,
    EV_ADDR_RD = 3'd4,
    EV_DATA_WR = 3'd5,
    EV_DATA_RD = 3'd6
  } ev_kind_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_REG,
    ST_WDATA,
    ST_RWAIT,
    ST_RDATA
  } mon_state_e;

  typedef struct packed {
    logic [6:0] sec;
    logic [6:0] min;
    logic [5:0] hour;
    logic [2:0] day;
    logic [5:0] date;
    logic [4:0] month;
    logic [7:0] year;
  } dt_fields_t;

  function automatic logic [7:0] bcd_to_bin(input logic [7:0] b);
    return 8'(b[3:0]) + 8'(b[7:4]) * 8'd10;
  endfunction

endpackage

// File: rtl/rtc_mon_fsm.sv
module rtc_mon_fsm
  import rtc_mon_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter logic [ADDR_W-1:0] SLAVE_ADDR = 7'h68,
  parameter int PTR_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ev_valid_i,
  input  logic [2:0]        ev_kind_i,
  input  logic [ADDR_W-1:0] ev_addr_i,
  output logic              fire_o,
  output logic              fire_wr_o,
  output logic [PTR_W-1:0]  ptr_o,
  output logic              clr_o,
  output logic              warn_o
);

  mon_state_e       st_q, st_d;
  logic [PTR_W-1:0] ptr_q, ptr_d;
  ev_kind_e         kind;
  logic             addr_ok;

  assign kind    = ev_kind_e'(ev_kind_i);
  assign addr_ok = (ev_addr_i == SLAVE_ADDR);
  assign ptr_o   = ptr_q;

  always_comb begin
    st_d      = st_q;
    ptr_d     = ptr_q;
    fire_o    = 1'b0;
    fire_wr_o = 1'b0;
    clr_o     = 1'b0;
    warn_o    = 1'b0;
    if (ev_valid_i) begin
      if (kind == EV_STOP) begin
        st_d = ST_IDLE;
      end else begin
        case (st_q)
          ST_IDLE: if (kind == EV_START) st_d = ST_ADDR;
          ST_ADDR: begin
            if (kind == EV_START || kind == EV_RSTART) st_d = ST_IDLE;
            else if (kind == EV_ADDR_WR || kind == EV_ADDR_RD) begin
              if (addr_ok) begin
                clr_o = 1'b1;
                st_d  = (kind == EV_ADDR_WR) ? ST_REG : ST_RDATA;
              end else begin
                warn_o = 1'b1;
                st_d   = ST_IDLE;
              end
            end
          end
          ST_REG: begin
            if (kind == EV_START || kind == EV_RSTART) st_d = ST_IDLE;
            else if (kind == EV_DATA_WR) begin
              ptr_d = ev_addr_i[PTR_W-1:0];
              st_d  = ST_WDATA;
            end
          end
          ST_WDATA: begin
            if (kind == EV_START) st_d = ST_IDLE;
            else if (kind == EV_RSTART) st_d = ST_RWAIT;
            else if (kind == EV_DATA_WR) begin
              fire_o    = 1'b1;
              fire_wr_o = 1'b1;
            end
          end
          ST_RWAIT: begin
            if (kind == EV_START || kind == EV_RSTART) st_d = ST_IDLE;
            else if (kind == EV_ADDR_RD) begin
              if (addr_ok) begin
                clr_o = 1'b1;
                st_d  = ST_RDATA;
              end else begin
                warn_o = 1'b1;
                st_d   = ST_IDLE;
              end
            end
          end
          ST_RDATA: begin
            if (kind == EV_START || kind == EV_RSTART) st_d = ST_IDLE;
            else if (kind == EV_DATA_RD) fire_o = 1'b1;
          end
          default: st_d = ST_IDLE;
        endcase
      end
    end
    if (fire_o) ptr_d = ptr_q + 1'b1;  // natural wrap at 2**PTR_W
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      ptr_q <= '0;
    end else begin
      st_q  <= st_d;
      ptr_q <= ptr_d;
    end
  end

  AST_STOP_TO_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_valid_i && kind == EV_STOP) |=> (st_q == ST_IDLE)); // R8
  AST_PTR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_o |=> (ptr_q == PTR_W'($past(ptr_q) + 1'b1))); // R6
  AST_REJECT_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    warn_o |=> (st_q == ST_IDLE)); // R2
  AST_IDLE_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE) |-> !(fire_o || warn_o || clr_o)); // R1

endmodule

// File: rtl/rtc_mon_report.sv
module rtc_mon_report #(
  parameter int ADDR_W     = 7,
  parameter int PTR_W      = 6,
  parameter int N_CLK_REGS = 8,
  parameter int RATE_REG   = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fire_i,
  input  logic              fire_wr_i,
  input  logic [PTR_W-1:0]  ptr_i,
  input  logic              warn_i,
  input  logic [7:0]        byte_i,
  output logic              acc_valid_o,
  output logic              acc_write_o,
  output logic [PTR_W-1:0]  acc_reg_o,
  output logic [7:0]        acc_data_o,
  output logic              acc_is_ram_o,
  output logic              acc_sqw32k_o,
  output logic              warn_valid_o,
  output logic [ADDR_W-1:0] warn_addr_o
);

  localparam logic [PTR_W-1:0] RAM_BASE = PTR_W'(N_CLK_REGS);
  localparam logic [PTR_W-1:0] RATE_IDX = PTR_W'(RATE_REG);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_valid_o  <= 1'b0;
      acc_write_o  <= 1'b0;
      acc_reg_o    <= '0;
      acc_data_o   <= '0;
      acc_is_ram_o <= 1'b0;
      acc_sqw32k_o <= 1'b0;
      warn_valid_o <= 1'b0;
      warn_addr_o  <= '0;
    end else begin
      acc_valid_o  <= fire_i;
      acc_sqw32k_o <= fire_i && (ptr_i == RATE_IDX) && (byte_i[1:0] == 2'b11);
      warn_valid_o <= warn_i;
      if (fire_i) begin
        acc_write_o  <= fire_wr_i;
        acc_reg_o    <= ptr_i;
        acc_data_o   <= byte_i;
        acc_is_ram_o <= (ptr_i >= RAM_BASE);
      end
      if (warn_i) warn_addr_o <= byte_i[ADDR_W-1:0];
    end
  end

  AST_ACC_WARN_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(acc_valid_o && warn_valid_o)); // R2
  AST_SQW_NEEDS_ACC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_sqw32k_o |-> (acc_valid_o && !acc_is_ram_o)); // R11
  AST_PULSE_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    warn_valid_o |=> !warn_valid_o); // R12

endmodule

// File: rtl/rtc_mon_dt.sv
module rtc_mon_dt
  import rtc_mon_pkg::*;
#(
  parameter int PTR_W  = 6,
  parameter int N_TIME = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fire_i,
  input  logic             fire_wr_i,
  input  logic [PTR_W-1:0] ptr_i,
  input  logic [7:0]       byte_i,
  input  logic             clr_i,
  output logic             dt_valid_o,
  output logic             dt_write_o,
  output dt_fields_t       dt_o
);

  localparam logic [N_TIME-1:0] ALL_SEEN = '1;

  logic [N_TIME-1:0] mask_q, hit;
  logic              is_time;

  assign is_time = fire_i && (ptr_i < PTR_W'(N_TIME));
  assign hit     = is_time ? (N_TIME'(1) << ptr_i) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q     <= '0;
      dt_valid_o <= 1'b0;
      dt_write_o <= 1'b0;
      dt_o       <= '0;
    end else begin
      dt_valid_o <= 1'b0;
      if (clr_i) begin
        mask_q <= '0;
      end else if (is_time) begin
        case (ptr_i)
          PTR_W'(0): dt_o.sec   <= 7'(bcd_to_bin({1'b0, byte_i[6:0]}));  // drop clock-halt
          PTR_W'(1): dt_o.min   <= 7'(bcd_to_bin({1'b0, byte_i[6:0]}));
          PTR_W'(2): dt_o.hour  <= 6'(bcd_to_bin({2'b00, byte_i[5:0]})); // drop mode bits
          PTR_W'(3): dt_o.day   <= 3'(bcd_to_bin({5'b0, byte_i[2:0]}));
          PTR_W'(4): dt_o.date  <= 6'(bcd_to_bin({2'b00, byte_i[5:0]}));
          PTR_W'(5): dt_o.month <= 5'(bcd_to_bin({3'b000, byte_i[4:0]}));
          PTR_W'(6): dt_o.year  <= bcd_to_bin(byte_i);
          default: ;
        endcase
        if ((mask_q | hit) == ALL_SEEN) begin
          dt_valid_o <= 1'b1;
          dt_write_o <= fire_wr_i;
          mask_q     <= '0;
        end else begin
          mask_q <= mask_q | hit;
        end
      end
    end
  end

  AST_DT_FROM_ACCESS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dt_valid_o |-> $past(fire_i)); // R10
  AST_DT_MASK_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dt_valid_o |-> (mask_q == '0)); // R10

endmodule

// File: rtl/rtc_bus_monitor.sv
module rtc_bus_monitor
  import rtc_mon_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter logic [ADDR_W-1:0] SLAVE_ADDR = 7'h68,
  parameter int PTR_W = 6,
  parameter int N_CLK_REGS = 8,
  parameter int RATE_REG = 7,
  parameter int N_TIME = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ev_valid_i,
  input  logic [2:0]        ev_kind_i,
  input  logic [7:0]        ev_byte_i,
  output logic              acc_valid_o,
  output logic              acc_write_o,
  output logic [PTR_W-1:0]  acc_reg_o,
  output logic [7:0]        acc_data_o,
  output logic              acc_is_ram_o,
  output logic              acc_sqw32k_o,
  output logic              warn_valid_o,
  output logic [ADDR_W-1:0] warn_addr_o,
  output logic              dt_valid_o,
  output logic              dt_write_o,
  output logic [6:0]        dt_sec_o,
  output logic [6:0]        dt_min_o,
  output logic [5:0]        dt_hour_o,
  output logic [2:0]        dt_day_o,
  output logic [5:0]        dt_date_o,
  output logic [4:0]        dt_month_o,
  output logic [7:0]        dt_year_o
);

  logic             fire, fire_wr, clr, warn;
  logic [PTR_W-1:0] ptr;
  dt_fields_t       dt;

  rtc_mon_fsm #(
    .ADDR_W(ADDR_W), .SLAVE_ADDR(SLAVE_ADDR), .PTR_W(PTR_W)
  ) u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .ev_valid_i(ev_valid_i), .ev_kind_i(ev_kind_i),
    .ev_addr_i(ev_byte_i[ADDR_W-1:0]),
    .fire_o(fire), .fire_wr_o(fire_wr), .ptr_o(ptr),
    .clr_o(clr), .warn_o(warn)
  );

  rtc_mon_report #(
    .ADDR_W(ADDR_W), .PTR_W(PTR_W), .N_CLK_REGS(N_CLK_REGS), .RATE_REG(RATE_REG)
  ) u_report (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .fire_i(fire), .fire_wr_i(fire_wr), .ptr_i(ptr), .warn_i(warn),
    .byte_i(ev_byte_i),
    .acc_valid_o(acc_valid_o), .acc_write_o(acc_write_o),
    .acc_reg_o(acc_reg_o), .acc_data_o(acc_data_o),
    .acc_is_ram_o(acc_is_ram_o), .acc_sqw32k_o(acc_sqw32k_o),
    .warn_valid_o(warn_valid_o), .warn_addr_o(warn_addr_o)
  );

  rtc_mon_dt #(
    .PTR_W(PTR_W), .N_TIME(N_TIME)
  ) u_dt (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .fire_i(fire), .fire_wr_i(fire_wr), .ptr_i(ptr), .byte_i(ev_byte_i),
    .clr_i(clr),
    .dt_valid_o(dt_valid_o), .dt_write_o(dt_write_o), .dt_o(dt)
  );

  assign dt_sec_o   = dt.sec;
  assign dt_min_o   = dt.min;
  assign dt_hour_o  = dt.hour;
  assign dt_day_o   = dt.day;
  assign dt_date_o  = dt.date;
  assign dt_month_o = dt.month;
  assign dt_year_o  = dt.year;

endmodule

// File: tb/rtc_bus_monitor_tb.sv
module rtc_bus_monitor_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ev_valid = 1'b0;
  logic [2:0] ev_kind = 3'd0;
  logic [7:0] ev_byte = 8'd0;

  logic       acc_valid, acc_write, acc_is_ram, acc_sqw32k, warn_valid, dt_valid, dt_write;
  logic [5:0] acc_reg, dt_hour, dt_date;
  logic [7:0] acc_data, dt_year;
  logic [6:0] warn_addr, dt_sec, dt_min;
  logic [2:0] dt_day;
  logic [4:0] dt_month;

  always #2.5 clk = ~clk;  // 200 MHz

  rtc_bus_monitor u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .ev_valid_i(ev_valid), .ev_kind_i(ev_kind), .ev_byte_i(ev_byte),
    .acc_valid_o(acc_valid), .acc_write_o(acc_write), .acc_reg_o(acc_reg),
    .acc_data_o(acc_data), .acc_is_ram_o(acc_is_ram), .acc_sqw32k_o(acc_sqw32k),
    .warn_valid_o(warn_valid), .warn_addr_o(warn_addr),
    .dt_valid_o(dt_valid), .dt_write_o(dt_write),
    .dt_sec_o(dt_sec), .dt_min_o(dt_min), .dt_hour_o(dt_hour), .dt_day_o(dt_day),
    .dt_date_o(dt_date), .dt_month_o(dt_month), .dt_year_o(dt_year)
  );

  localparam int K_START = 0, K_RSTART = 1, K_STOP = 2, K_AW = 3, K_AR = 4, K_DW = 5, K_DR = 6;
  localparam int M_IDLE = 0, M_ADDR = 1, M_REG = 2, M_WDATA = 3, M_RWAIT = 4, M_RDATA = 5;

  int checks = 0, failures = 0;
  string cur_req = "R12";

  // behavioural reference state
  int m_st = M_IDLE, m_ptr = 0, m_seen = 0;
  int m_f[7] = '{0, 0, 0, 0, 0, 0, 0};
  bit e_av = 0, e_aw = 0, e_ram = 0, e_sqw = 0, e_wv = 0, e_dv = 0, e_dw = 0;
  int e_reg = 0, e_data = 0, e_waddr = 0;

  function automatic int bcd(input int b);
    return (b / 16) * 10 + (b % 16);
  endfunction

  task automatic chk(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", cur_req, what, act, exp);
    end
  endtask

  task automatic compare();
    chk("acc_valid", int'(acc_valid), int'(e_av));
    if (e_av) begin
      chk("acc_write", int'(acc_write), int'(e_aw));
      chk("acc_reg", int'(acc_reg), e_reg);
      chk("acc_data", int'(acc_data), e_data);
      chk("acc_is_ram", int'(acc_is_ram), int'(e_ram));
    end
    chk("acc_sqw32k", int'(acc_sqw32k), int'(e_sqw));
    chk("warn_valid", int'(warn_valid), int'(e_wv));
    if (e_wv) chk("warn_addr", int'(warn_addr), e_waddr);
    chk("dt_valid", int'(dt_valid), int'(e_dv));
    if (e_dv) chk("dt_write", int'(dt_write), int'(e_dw));
    chk("dt_sec", int'(dt_sec), m_f[0]);
    chk("dt_min", int'(dt_min), m_f[1]);
    chk("dt_hour", int'(dt_hour), m_f[2]);
    chk("dt_day", int'(dt_day), m_f[3]);
    chk("dt_date", int'(dt_date), m_f[4]);
    chk("dt_month", int'(dt_month), m_f[5]);
    chk("dt_year", int'(dt_year), m_f[6]);
  endtask

  task automatic access(input bit wr, input int b);
    e_av = 1; e_aw = wr; e_reg = m_ptr; e_data = b; e_ram = (m_ptr >= 8);
    e_sqw = (m_ptr == 7) && ((b % 4) == 3);
    if (m_ptr < 7) begin
      case (m_ptr)
        0: m_f[0] = bcd(b % 128);
        1: m_f[1] = bcd(b % 128);
        2: m_f[2] = bcd(b % 64);
        3: m_f[3] = bcd(b % 8);
        4: m_f[4] = bcd(b % 64);
        5: m_f[5] = bcd(b % 32);
        default: m_f[6] = bcd(b);
      endcase
      m_seen = m_seen | (1 << m_ptr);
      if (m_seen == 127) begin e_dv = 1; e_dw = wr; m_seen = 0; end
    end
    m_ptr = (m_ptr + 1) % 64;
  endtask

  task automatic model(input bit v, input int k, input int b);
    bit ok;
    e_av = 0; e_sqw = 0; e_wv = 0; e_dv = 0;
    ok = ((b % 128) == 'h68);
    if (!v) return;
    if (k == K_STOP) begin m_st = M_IDLE; return; end
    case (m_st)
      M_IDLE: if (k == K_START) m_st = M_ADDR;
      M_ADDR:
        if (k == K_START || k == K_RSTART) m_st = M_IDLE;
        else if (k == K_AW || k == K_AR) begin
          if (ok) begin m_seen = 0; m_st = (k == K_AW) ? M_REG : M_RDATA; end
          else begin e_wv = 1; e_waddr = b % 128; m_st = M_IDLE; end
        end
      M_REG:
        if (k == K_START || k == K_RSTART) m_st = M_IDLE;
        else if (k == K_DW) begin m_ptr = b % 64; m_st = M_WDATA; end
      M_WDATA:
        if (k == K_START) m_st = M_IDLE;
        else if (k == K_RSTART) m_st = M_RWAIT;
        else if (k == K_DW) access(1, b);
      M_RWAIT:
        if (k == K_START || k == K_RSTART) m_st = M_IDLE;
        else if (k == K_AR) begin
          if (ok) begin m_seen = 0; m_st = M_RDATA; end
          else begin e_wv = 1; e_waddr = b % 128; m_st = M_IDLE; end
        end
      default:
        if (k == K_START || k == K_RSTART) m_st = M_IDLE;
        else if (k == K_DR) access(0, b);
    endcase
  endtask

  task automatic step(input bit v, input int k, input int b);
    @(negedge clk);
    compare();
    model(v, k, b);
    ev_valid = v; ev_kind = k[2:0]; ev_byte = b[7:0];
  endtask

  task automatic ev(input int k, input int b);
    step(1, k, b);
  endtask

  task automatic gap(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    summary();
  end

  initial begin
    cur_req = "R12 reset";
    gap(3);
    rst_n = 1'b1;
    gap(2);

    // R1: nothing before a start
    cur_req = "R1";
    ev(K_AW, 'h68); ev(K_DW, 'h00); ev(K_DW, 'h11); ev(K_DR, 'h22); gap(2);

    // R2: foreign write address
    cur_req = "R2";
    ev(K_START, 0); ev(K_AW, 'h50); ev(K_DW, 'h03); ev(K_DW, 'h44); ev(K_STOP, 0); gap(1);

    // R3 R4 R9 R10 R11 R7: write burst over time, control and RAM
    cur_req = "R3";
    ev(K_START, 0); ev(K_AW, 'h68); ev(K_DW, 'h00);
    cur_req = "R9";
    ev(K_DW, 'hC5); ev(K_DW, 'h59); ev(K_DW, 'h52); ev(K_DW, 'h01);
    ev(K_DW, 'h31); ev(K_DW, 'h12);
    cur_req = "R10";
    ev(K_DW, 'h99);
    cur_req = "R11";
    ev(K_DW, 'h13);
    cur_req = "R7";
    ev(K_DW, 'h55);
    cur_req = "R4";
    ev(K_STOP, 0); gap(2);

    // R5 R6: read burst wrapping 0x3E..0x07
    cur_req = "R5";
    ev(K_START, 0); ev(K_AW, 'h68); ev(K_DW, 'h3E); ev(K_RSTART, 0); ev(K_AR, 'h68);
    cur_req = "R6";
    ev(K_DR, 'hAA); ev(K_DR, 'h0F); ev(K_DR, 'h30); ev(K_DR, 'h07); ev(K_DR, 'h23);
    ev(K_DR, 'h07); ev(K_DR, 'h28); ev(K_DR, 'h02);
    cur_req = "R10";
    ev(K_DR, 'h24);
    cur_req = "R11";
    ev(K_DR, 'h03);
    ev(K_STOP, 0); gap(1);

    // R5: foreign read address after a repeated start
    cur_req = "R5";
    ev(K_START, 0); ev(K_AW, 'h68); ev(K_DW, 'h10); ev(K_RSTART, 0); ev(K_AR, 'h69);
    ev(K_DR, 'h77); gap(2);

    // R8: current-address read from kept pointer, misplaced start
    cur_req = "R8";
    ev(K_START, 0); ev(K_AR, 'h68); ev(K_DR, 'h01); ev(K_DR, 'h02);
    ev(K_START, 0); ev(K_DR, 'h03); ev(K_STOP, 0);
    ev(K_START, 0); ev(K_AW, 'h68); ev(K_RSTART, 0); ev(K_DW, 'h05); ev(K_DW, 'h06);
    ev(K_START, 0); ev(K_AW, 'h68); ev(K_STOP, 0); ev(K_DW, 'h07);
    ev(K_START, 0); ev(K_AR, 'h68); ev(K_DR, 'h08);
    cur_req = "R12";
    gap(3);

    summary();
  end

endmodule